// File: doc/BRIEF.md
# Instruction Ring Doorbell Controller

This block manages one instruction ring that lives in host memory and feeds an offload engine. Software sets up the ring through a small register port: a base address, the ring length counted in instructions, the instruction width (32 or 64 bytes) and an enable. Work is posted by writing doorbell increments. Each increment adds to a pending count rather than moving a pointer.

While the ring is enabled and work is pending, the block issues one fetch at a time on a request/acknowledge memory port. The fetch address is the base plus the current read offset. Each fetch consumes one pending unit and moves the offset forward by one instruction, wrapping at the end of the ring. Every acknowledged fetch adds one to a completion counter. An interrupt line stays high while that counter is above a programmed level. Software acknowledges completions by writing an amount, which is subtracted from the counter. That write drops the interrupt once the count falls to or below the level.

Top module: `ring_dbell_ctrl`

## Requirements
- R1: After synchronous reset every register reads zero, `fetch_req` is low and `ring_irq` is low.
- R2: Register select codes are 0 control, 1 base, 2 size, 3 doorbell, 4 offset (read only), 5 completion count, 6 interrupt level. A read strobe returns the selected value on `cfg_rdata` in the following cycle. A write to select 3 adds the written value to the pending count, and a read of select 3 returns that count.
- R3: A fetch is issued only while control bit 0 (enable) is 1, the pending count is nonzero and the ring size is nonzero. Each issued fetch lowers the pending count by exactly one.
- R4: Control bit 1 selects the instruction size: 1 means 64 bytes and 0 means 32 bytes. The fetch address equals base + index × instruction size.
- R5: Each fetch advances the index by one, and the index returns to 0 after reaching size − 1. Select 4 reads index × instruction size. A write to the size register sets the index to 0.
- R6: Only one fetch is outstanding at a time. `fetch_req` and `fetch_addr` hold steady until `fetch_ack`, and `fetch_ack` while `fetch_req` is low has no effect.
- R7: Each accepted fetch (request and acknowledge high together) adds one to the completion count. A write to select 5 subtracts the written value.
- R8: `ring_irq` is high exactly when the completion count exceeds the level register. It falls in the same cycle a subtracting write brings the count to or below the level.
- R9: Clearing the enable while a fetch is outstanding lets that fetch complete and be counted, and no further fetch is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Read data, valid the cycle after `cfg_rd` |
| fetch_req | output | 1 | Fetch request, held until acknowledged |
| fetch_addr | output | ADDR_W | Byte address of the instruction to fetch |
| fetch_ack | input | 1 | Fetch acknowledge |
| ring_irq | output | 1 | Completion count above level |

## Verification
The bench posts doorbells while the ring is disabled. A design that fetched early, or that overwrote the count instead of adding to it, would show the wrong pending value or unexpected requests. The fetch address sequence crosses the ring end in both instruction sizes, so an off-by-one wrap would produce an address past the ring or a skipped slot. Completion writes bring the count to exactly the level, where a design comparing with greater-or-equal would leave the interrupt high. Disabling during a slow acknowledge catches both a dropped in-flight fetch and an extra fetch after the disable. A stray acknowledge with no request would inflate the completion count.

// File: rtl/ring_pkg.sv
package ring_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL   = 3'd0,
    SEL_BASE   = 3'd1,
    SEL_SIZE   = 3'd2,
    SEL_DBELL  = 3'd3,
    SEL_OFFSET = 3'd4,
    SEL_DONE   = 3'd5,
    SEL_LEVEL  = 3'd6
  } reg_sel_e;

  localparam int SHIFT_NARROW = 5;
  localparam int SHIFT_WIDE   = 6;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_WIDE_BIT = 1;
endpackage

// File: rtl/ring_cfg_regs.sv
module ring_cfg_regs
  import ring_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  output logic              ctrl_en,
  output logic              ctrl_wide,
  output logic [ADDR_W-1:0] base,
  output logic [SIZE_W-1:0] size,
  output logic [CNT_W-1:0]  level,
  output logic [CNT_W-1:0]  level_nxt,
  output logic              size_wr
);
  always_comb begin
    size_wr   = we && (sel == SEL_SIZE);
    level_nxt = (we && sel == SEL_LEVEL) ? CNT_W'(wdata) : level;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en   <= 1'b0;
      ctrl_wide <= 1'b0;
      base      <= '0;
      size      <= '0;
      level     <= '0;
    end else begin
      level <= level_nxt;
      if (we) begin
        case (sel)
          SEL_CTRL: begin
            ctrl_en   <= wdata[CTRL_EN_BIT];
            ctrl_wide <= wdata[CTRL_WIDE_BIT];
          end
          SEL_BASE: base <= ADDR_W'(wdata);
          SEL_SIZE: size <= SIZE_W'(wdata);
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ring_fetch_ctrl.sv
module ring_fetch_ctrl
  import ring_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wide,
  input  logic [ADDR_W-1:0] base,
  input  logic [SIZE_W-1:0] size,
  input  logic              size_wr,
  input  logic              db_we,
  input  logic [DATA_W-1:0] db_val,
  input  logic              ack,
  output logic              req,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  pending,
  output logic [SIZE_W-1:0] idx
);
  logic              can_issue;
  logic [CNT_W-1:0]  pend_nxt;
  logic [SIZE_W:0]   idx_inc;
  logic              at_end;
  logic [ADDR_W-1:0] slot_ofs;

  always_comb begin
    can_issue = !req && en && (pending != '0) && (size != '0);
    pend_nxt  = pending
              + (db_we ? CNT_W'(db_val) : '0)
              - (can_issue ? CNT_W'(1) : '0);
    idx_inc   = {1'b0, idx} + 1'b1;
    at_end    = idx_inc >= {1'b0, size};
    slot_ofs  = ADDR_W'(idx) << (wide ? SHIFT_WIDE : SHIFT_NARROW);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req     <= 1'b0;
      addr    <= '0;
      pending <= '0;
      idx     <= '0;
    end else begin
      pending <= pend_nxt;
      if (req && ack) begin
        req <= 1'b0;
      end else if (can_issue) begin
        req  <= 1'b1;
        addr <= base + slot_ofs;
      end
      if (size_wr) begin
        idx <= '0;
      end else if (can_issue) begin
        idx <= at_end ? '0 : idx_inc[SIZE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/ring_done_cnt.sv
module ring_done_cnt #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              sub_we,
  input  logic [DATA_W-1:0] sub_val,
  input  logic [CNT_W-1:0]  level_nxt,
  output logic [CNT_W-1:0]  done,
  output logic              irq
);
  logic [CNT_W-1:0] done_nxt;

  always_comb begin
    done_nxt = done
             + (accept ? CNT_W'(1) : '0)
             - (sub_we ? CNT_W'(sub_val) : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= '0;
      irq  <= 1'b0;
    end else begin
      done <= done_nxt;
      irq  <= done_nxt > level_nxt;
    end
  end
endmodule

// File: rtl/ring_dbell_ctrl.sv
module ring_dbell_ctrl
  import ring_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [2:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_ack,
  output logic              ring_irq
);
  localparam int OFS_W = SIZE_W + SHIFT_WIDE;

  reg_sel_e          sel;
  logic              ctrl_en;
  logic              ctrl_wide;
  logic [ADDR_W-1:0] base;
  logic [SIZE_W-1:0] size;
  logic [CNT_W-1:0]  level;
  logic [CNT_W-1:0]  level_nxt;
  logic              size_wr;
  logic              db_we;
  logic              done_we;
  logic              accept;
  logic [CNT_W-1:0]  pending;
  logic [SIZE_W-1:0] idx;
  logic [CNT_W-1:0]  done;
  logic [OFS_W-1:0]  byte_ofs;

  always_comb begin
    sel      = reg_sel_e'(cfg_addr);
    db_we    = cfg_wr && (sel == SEL_DBELL);
    done_we  = cfg_wr && (sel == SEL_DONE);
    accept   = fetch_req && fetch_ack;
    byte_ofs = {idx, {SHIFT_WIDE{1'b0}}} >> (ctrl_wide ? 0 : 1);
  end

  ring_cfg_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_wr), .sel(sel), .wdata(cfg_wdata),
    .ctrl_en(ctrl_en), .ctrl_wide(ctrl_wide), .base(base), .size(size),
    .level(level), .level_nxt(level_nxt), .size_wr(size_wr)
  );

  ring_fetch_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W)
  ) u_fetch (
    .clk(clk), .rst(rst), .en(ctrl_en), .wide(ctrl_wide), .base(base),
    .size(size), .size_wr(size_wr), .db_we(db_we), .db_val(cfg_wdata),
    .ack(fetch_ack), .req(fetch_req), .addr(fetch_addr),
    .pending(pending), .idx(idx)
  );

  ring_done_cnt #(
    .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_done (
    .clk(clk), .rst(rst), .accept(accept), .sub_we(done_we),
    .sub_val(cfg_wdata), .level_nxt(level_nxt), .done(done), .irq(ring_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else if (cfg_rd) begin
      case (sel)
        SEL_CTRL:   cfg_rdata <= DATA_W'({ctrl_wide, ctrl_en});
        SEL_BASE:   cfg_rdata <= DATA_W'(base);
        SEL_SIZE:   cfg_rdata <= DATA_W'(size);
        SEL_DBELL:  cfg_rdata <= DATA_W'(pending);
        SEL_OFFSET: cfg_rdata <= DATA_W'(byte_ofs);
        SEL_DONE:   cfg_rdata <= DATA_W'(done);
        SEL_LEVEL:  cfg_rdata <= DATA_W'(level);
        default:    cfg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ring_dbell_ctrl_chk.sv
module ring_dbell_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_req,
  input logic              fetch_ack,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              ctrl_en,
  input logic [CNT_W-1:0]  pending,
  input logic              db_we,
  input logic              done_we,
  input logic [CNT_W-1:0]  done,
  input logic [CNT_W-1:0]  level,
  input logic              ring_irq,
  input logic [SIZE_W-1:0] size,
  input logic [SIZE_W-1:0] idx
);
  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_req && !fetch_ack |=> fetch_req && $stable(fetch_addr));

  // R3
  issue_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fetch_req) |-> $past(ctrl_en) && ($past(pending) != '0));

  // R3
  pend_step_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fetch_req) && !$past(db_we) |-> pending == $past(pending) - 1'b1);

  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    ring_irq == (done > level));

  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    (size != '0) |-> idx < size);

  // R7
  done_step_chk: assert property (@(posedge clk) disable iff (rst)
    $past(fetch_req && fetch_ack) && !$past(done_we) |-> done == $past(done) + 1'b1);
endmodule

bind ring_dbell_ctrl ring_dbell_ctrl_chk #(
  .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_ack(fetch_ack),
  .fetch_addr(fetch_addr), .ctrl_en(ctrl_en), .pending(pending),
  .db_we(db_we), .done_we(done_we), .done(done), .level(level),
  .ring_irq(ring_irq), .size(size), .idx(idx)
);

// File: tb/ring_dbell_ctrl_tb.sv
module ring_dbell_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic        cfg_rd = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        fetch_req;
  logic [31:0] fetch_addr;
  logic        fetch_ack = 1'b0;
  logic        ring_irq;

  int errors = 0;
  int checks = 0;
  int ack_lat = 1;
  logic [31:0] exp_q[$];
  logic [31:0] m_base = '0;
  int          m_size = 0;
  int          m_idx = 0;
  int          m_shift = 5;
  logic [31:0] rd_val;

  always #5 clk = ~clk;

  ring_dbell_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack),
    .ring_irq(ring_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    d = cfg_rdata;
  endtask

  // driver: predicts fetch addresses, then rings the doorbell
  task automatic post(input int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(m_base + (32'(m_idx) << m_shift));
      m_idx = (m_idx + 1 >= m_size) ? 0 : m_idx + 1;
    end
    reg_write(3'd3, 32'(n));
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !fetch_req && !fetch_ack) break;
    end
    repeat (3) @(negedge clk);
  endtask

  // monitor: acknowledges requests and compares against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && fetch_req && !fetch_ack) begin
        if (exp_q.size() == 0) begin
          check("R3 unexpected fetch", fetch_addr, 32'hFFFF_FFFF);
        end else begin
          check("R4 fetch address", fetch_addr, exp_q.pop_front());
        end
        repeat (ack_lat) @(negedge clk);
        fetch_ack = 1'b1;
        @(negedge clk);
        fetch_ack = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 fetch_req", {31'b0, fetch_req}, 32'd0);
    check("R1 ring_irq", {31'b0, ring_irq}, 32'd0);
    reg_read(3'd0, rd_val); check("R1 ctrl", rd_val, 32'd0);
    reg_read(3'd3, rd_val); check("R1 doorbell", rd_val, 32'd0);
    reg_read(3'd5, rd_val); check("R1 done", rd_val, 32'd0);

    // configure a ring of 4 x 32-byte slots, level 2
    m_base = 32'h1000_0000; m_size = 4; m_shift = 5; m_idx = 0;
    reg_write(3'd1, m_base);
    reg_write(3'd2, 32'd4);
    reg_write(3'd6, 32'd2);
    reg_read(3'd1, rd_val); check("R2 base readback", rd_val, 32'h1000_0000);

    // R2 doorbells accumulate while disabled; R3 nothing fetched
    post(3);
    post(2);
    reg_read(3'd3, rd_val); check("R2 doorbell sum", rd_val, 32'd5);
    repeat (5) @(negedge clk);
    check("R3 no fetch when disabled", {31'b0, fetch_req}, 32'd0);

    // enable: 5 fetches, wrapping past slot 3 (R5)
    reg_write(3'd0, 32'd1);
    wait_idle();
    reg_read(3'd3, rd_val); check("R3 pending drained", rd_val, 32'd0);
    reg_read(3'd5, rd_val); check("R7 done after 5", rd_val, 32'd5);
    check("R8 irq above level", {31'b0, ring_irq}, 32'd1);
    reg_read(3'd4, rd_val); check("R5 offset 32B", rd_val, 32'h20);

    // R7 / R8 subtracting writes
    reg_write(3'd5, 32'd2);
    reg_read(3'd5, rd_val); check("R7 done after subtract", rd_val, 32'd3);
    check("R8 irq still above", {31'b0, ring_irq}, 32'd1);
    reg_write(3'd5, 32'd1);
    check("R8 irq clears at level", {31'b0, ring_irq}, 32'd0);
    reg_read(3'd5, rd_val); check("R7 done equals level", rd_val, 32'd2);

    // R5 size write resets index; R4 64-byte mode
    reg_write(3'd2, 32'd3);
    m_size = 3; m_idx = 0;
    reg_read(3'd4, rd_val); check("R5 offset reset by size write", rd_val, 32'd0);
    reg_write(3'd0, 32'd3);
    m_shift = 6;
    post(4);
    wait_idle();
    reg_read(3'd5, rd_val); check("R7 done after 64B run", rd_val, 32'd6);
    check("R8 irq high again", {31'b0, ring_irq}, 32'd1);
    reg_read(3'd4, rd_val); check("R5 offset 64B", rd_val, 32'h40);

    // R9 disable with a fetch in flight
    ack_lat = 5;
    post(2);
    reg_write(3'd0, 32'd2);
    repeat (20) @(negedge clk);
    check("R9 no fetch after disable", {31'b0, fetch_req}, 32'd0);
    reg_read(3'd3, rd_val); check("R9 one unit left pending", rd_val, 32'd1);
    reg_read(3'd5, rd_val); check("R9 in-flight fetch counted", rd_val, 32'd7);

    // R6 stray acknowledge ignored
    @(negedge clk);
    fetch_ack = 1'b1;
    @(negedge clk);
    fetch_ack = 1'b0;
    reg_read(3'd5, rd_val); check("R6 stray ack ignored", rd_val, 32'd7);

    // re-enable and finish the remaining unit
    ack_lat = 1;
    reg_write(3'd0, 32'd3);
    wait_idle();
    reg_read(3'd5, rd_val); check("R7 done after resume", rd_val, 32'd8);
    reg_read(3'd3, rd_val); check("R3 pending empty", rd_val, 32'd0);

    // R8 raising the level drops the interrupt
    reg_write(3'd6, 32'd10);
    check("R8 irq below raised level", {31'b0, ring_irq}, 32'd0);
    check("R4 all predicted fetches seen", 32'(exp_q.size()), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule